// File: doc/BRIEF.md
# Serial Transmitter with Clear-to-Send Gating

This block sends bytes over an asynchronous serial line. Each frame is a low start bit, eight data bits with the least significant bit first, and a high stop bit. Every bit lasts a fixed, parameterised number of clock cycles. A byte is written into a one-entry holding register through a parallel write port. When the shifter is free, the byte moves from the holding register into the shifter, and the register-empty flag rises at once.

An active-low clear-to-send input can gate transmission when flow control is enabled. The input first passes through a two-flop synchronizer. It is then checked only at frame boundaries: when the line is idle, or on the final cycle of the stop bit. A byte written while the input is high waits until the input returns low. A frame that has already started always finishes.

While flow control is enabled, every toggle of the synchronized input sets a sticky change flag. A one-cycle strobe clears the flag, and a new toggle in the same cycle as the strobe wins over it. An interrupt output follows the flag whenever the interrupt-enable bit is set.

Top module: `uart_cts_tx`

## Requirements
- R1: The line idles high. A frame is a 0 start bit, then data bits 0 to 7, then a 1 stop bit. Each bit is held for CLKS_PER_BIT cycles, so a frame lasts 10*CLKS_PER_BIT cycles.
- R2: With flow_en=1, a frame starts only at a boundary where the holding register is full and the synchronized cts_n is 0. A byte written while cts_n is 1 stays pending, and the line stays high, until cts_n returns to 0.
- R3: If cts_n goes high while a frame is on the line, that frame completes in full, and no further frame starts until cts_n is low again.
- R4: With flow_en=0, cts_n has no effect on transmission and the change flag is never set.
- R5: With flow_en=1, a change of cts_n that is present before clock edge k sets cts_flag, which is visible after edge k+2. Both rising and falling changes set the flag.
- R6: A cts_flag_clr pulse clears cts_flag at the next edge. If a toggle is detected at that same edge, the flag stays set.
- R7: cts_irq equals cts_flag AND cts_irq_en.
- R8: tx_empty is 1 after reset and falls after the edge that accepts a write. It rises after the edge that moves the byte into the shifter. A write while tx_empty=0 is ignored.
- R9: When the next byte is held and cts_n has been low for at least 3 cycles before the last cycle of the stop bit, the next start bit follows the stop bit with no idle cycle.
- R10: During and right after reset, txd=1, tx_empty=1, cts_flag=0 and cts_irq=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| tx_empty | output | 1 | Holding register is empty |
| txd | output | 1 | Serial output, idle high |
| cts_n | input | 1 | Asynchronous clear-to-send, active low |
| flow_en | input | 1 | Enables clear-to-send gating and change detection |
| cts_irq_en | input | 1 | Interrupt enable for the change flag |
| cts_flag_clr | input | 1 | One-cycle strobe that clears the change flag |
| cts_flag | output | 1 | Sticky clear-to-send change flag |
| cts_irq | output | 1 | Interrupt output |

## Verification
Each result has its own latency:
- A write lowers tx_empty one edge later.
- A frame starts one edge after the byte is held. The start bit then appears on txd and tx_empty rises at that same edge.
- A cts_n change reaches the flag three edges after the input is presented, and it reaches the start gate two edges after.

The bench model pushes every cts_n sample into a queue and reads the entries that are two and three edges old. It times each frame with a single cycle counter. All four outputs are compared in the middle of the low clock phase on every cycle. Each phase of stimulus names the requirement it targets.

// File: rtl/uart_cts_pkg.sv
package uart_cts_pkg;
  localparam int DATA_W     = 8;
  localparam int FRAME_BITS = DATA_W + 2;

  // Frame image, shifted out from bit 0: start(0), data LSB first, stop(1).
  function automatic logic [FRAME_BITS-1:0] frame_bits(input logic [DATA_W-1:0] d);
    return {1'b1, d, 1'b0};
  endfunction

  // Line level when the line is idle (between frames).
  function automatic logic idle_level();
    return 1'b1;
  endfunction
endpackage

// File: rtl/cts_sync.sv
module cts_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n_async,
  output logic cts_n_sync,
  output logic cts_toggle
);
  logic meta_q, sync_q, hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      hist_q <= 1'b1;
    end else begin
      meta_q <= cts_n_async;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign cts_n_sync = sync_q;
  assign cts_toggle = sync_q ^ hist_q;
endmodule

// File: rtl/tx_hold.sv
module tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              valid,
  output logic [DATA_W-1:0] data
);
  logic accept;
  assign accept = wr_en && !valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else begin
      if (accept) begin
        valid <= 1'b1;
        data  <= wr_data;
      end else if (take) begin
        valid <= 1'b0;
      end
    end
  end

  // R8: a write into a full register leaves the stored byte untouched
  p_full_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !take) |=> (valid && $stable(data)));
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import uart_cts_pkg::*;
#(
  parameter int CLKS_PER_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_valid,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              cts_ok,
  output logic              frame_start,
  output logic              txd
);
  localparam int DIV_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLKS_PER_BIT - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

  logic                  busy;
  logic [DIV_W-1:0]      div_cnt;
  logic [BIT_W-1:0]      bit_cnt;
  logic [FRAME_BITS-1:0] shreg;
  logic                  bit_tick, last_tick;

  assign bit_tick    = busy && (div_cnt == DIV_LAST);
  assign last_tick   = bit_tick && (bit_cnt == BIT_LAST);
  assign frame_start = (!busy || last_tick) && hold_valid && cts_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      shreg   <= '1;
    end else if (frame_start) begin
      busy    <= 1'b1;
      div_cnt <= '0;
      bit_cnt <= '0;
      shreg   <= frame_bits(hold_data);
    end else if (busy) begin
      if (last_tick) begin
        busy <= 1'b0;
      end
      if (bit_tick) begin
        div_cnt <= '0;
        bit_cnt <= bit_cnt + 1'b1;
        shreg   <= {1'b1, shreg[FRAME_BITS-1:1]};
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  assign txd = busy ? shreg[0] : idle_level();

  // R3: a frame in progress is never cut short
  p_no_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_tick) |=> busy);
  // R1: the final cycle of every frame carries the stop level
  p_stop_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    last_tick |-> txd);
  // R1: the first cycle after a start carries the start level
  p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !txd);
endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx
  import uart_cts_pkg::*;
#(
  parameter int CLKS_PER_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tx_empty,
  output logic              txd,
  input  logic              cts_n,
  input  logic              flow_en,
  input  logic              cts_irq_en,
  input  logic              cts_flag_clr,
  output logic              cts_flag,
  output logic              cts_irq
);
  logic              cts_n_sync, cts_toggle, cts_ok;
  logic              hold_valid, frame_start;
  logic [DATA_W-1:0] hold_data;

  cts_sync u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .cts_n_async (cts_n),
    .cts_n_sync  (cts_n_sync),
    .cts_toggle  (cts_toggle)
  );

  assign cts_ok = !flow_en || !cts_n_sync;

  tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (frame_start),
    .valid   (hold_valid),
    .data    (hold_data)
  );

  tx_shifter #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_valid  (hold_valid),
    .hold_data   (hold_data),
    .cts_ok      (cts_ok),
    .frame_start (frame_start),
    .txd         (txd)
  );

  // Sticky change flag: a detected toggle wins over the clear strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_flag <= 1'b0;
    end else if (flow_en && cts_toggle) begin
      cts_flag <= 1'b1;
    end else if (cts_flag_clr) begin
      cts_flag <= 1'b0;
    end
  end

  assign tx_empty = !hold_valid;
  assign cts_irq  = cts_flag && cts_irq_en;

  // R2: with gating on, no frame begins while the synchronized input is high
  p_gate_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && frame_start) |-> !cts_n_sync);
  // R5, R6: a toggle under flow control always leaves the flag set
  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && cts_toggle) |=> cts_flag);
  // R4: with gating off, a clear flag stays clear
  p_flag_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_en && !cts_flag) |=> !cts_flag);
  // R8: the holding register is free right after a hand-over
  p_empty_after_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> tx_empty);
endmodule

// File: tb/uart_cts_tx_tb.sv
module uart_cts_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CPB        = 4;
  localparam int FRAME_CYC  = 10 * CPB;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       cts_n = 1'b1;
  logic       flow_en = 1'b0;
  logic       cts_irq_en = 1'b0;
  logic       cts_flag_clr = 1'b0;
  logic       tx_empty, txd, cts_flag, cts_irq;

  int    checks = 0;
  int    failures = 0;
  int    cycles = 0;
  bit    done = 1'b0;
  string tag = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_cts_tx #(.CLKS_PER_BIT(CPB)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .tx_empty(tx_empty), .txd(txd), .cts_n(cts_n), .flow_en(flow_en),
    .cts_irq_en(cts_irq_en), .cts_flag_clr(cts_flag_clr),
    .cts_flag(cts_flag), .cts_irq(cts_irq)
  );

  // Behavioural reference model
  bit       m_pend, m_on_line, m_flag;
  bit [7:0] m_pend_byte, m_line_byte;
  int       m_age;
  bit       cts_hist[$];

  function automatic bit line_level(bit on, int age, bit [7:0] b);
    int slot;
    if (!on) return 1'b1;
    slot = age / CPB;
    if (slot == 0) return 1'b0;
    if (slot == 9) return 1'b1;
    return b[slot-1];
  endfunction

  always @(posedge clk) begin
    bit seen2, seen3, may_go, at_end, go;
    if (!rst_n) begin
      m_pend = 0; m_on_line = 0; m_flag = 0; m_age = 0;
      cts_hist = '{1'b1, 1'b1, 1'b1};
    end else begin
      seen2  = cts_hist[cts_hist.size()-2];
      seen3  = cts_hist[cts_hist.size()-3];
      may_go = !flow_en || !seen2;
      at_end = m_on_line && (m_age == FRAME_CYC - 1);
      go     = (!m_on_line || at_end) && m_pend && may_go;
      if (flow_en && (seen2 != seen3)) m_flag = 1;
      else if (cts_flag_clr) m_flag = 0;
      if (go) begin
        m_on_line = 1; m_age = 0; m_line_byte = m_pend_byte; m_pend = 0;
      end else if (m_on_line) begin
        if (at_end) m_on_line = 0;
        else m_age++;
      end
      if (wr_en && !m_pend && !go) begin
        if (!(m_pend && go)) begin
          m_pend = 1; m_pend_byte = wr_data;
        end
      end
      cts_hist.push_back(cts_n);
      void'(cts_hist.pop_front());
    end
  end

  task automatic check1(string what, logic act, bit exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s t=%0t actual=%b expected=%b", tag, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      check1("txd R1",      txd,      line_level(m_on_line, m_age, m_line_byte));
      check1("tx_empty R8", tx_empty, !m_pend);
      check1("cts_flag R5", cts_flag, m_flag);
      check1("cts_irq R7",  cts_irq,  m_flag && cts_irq_en);
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog %s expired", tag);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic put(bit [7:0] b);
    @(negedge clk); wr_en = 1; wr_data = b;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_empty();
    while (!tx_empty) @(negedge clk);
  endtask

  initial begin
    tag = "R10";                       // reset state
    idle(3);
    @(negedge clk); rst_n = 1;
    idle(2);

    tag = "R1";                        // plain frames, flow off
    put(8'hA5); idle(FRAME_CYC + 5);
    put(8'h01); idle(FRAME_CYC + 5);

    tag = "R9";                        // back-to-back frames
    put(8'h3C); wait_empty(); put(8'hC3); wait_empty(); put(8'hFF);
    idle(3 * FRAME_CYC);

    tag = "R8";                        // second write while full is ignored
    put(8'h11); put(8'h22); put(8'h33); idle(3 * FRAME_CYC);

    tag = "R4";                        // flow off: cts_n ignored, flag quiet
    put(8'h5A);
    for (int i = 0; i < 6; i++) begin idle(7); cts_n = ~cts_n; end
    cts_n = 1; idle(FRAME_CYC);

    tag = "R2";                        // gated byte waits for cts_n low
    flow_en = 1; idle(5);
    put(8'h96); idle(30);
    cts_irq_en = 1;
    cts_n = 0; idle(FRAME_CYC + 5);

    tag = "R3";                        // cts_n rises mid-frame
    put(8'h69); idle(12); cts_n = 1;
    put(8'h0F); idle(2 * FRAME_CYC);
    cts_n = 0; idle(FRAME_CYC + 10);

    tag = "R9";                        // gated back-to-back with early cts_n
    put(8'hE7); wait_empty(); put(8'h18); idle(3 * FRAME_CYC);

    tag = "R6";                        // clear strobe against toggle timing
    for (int d = 0; d < 5; d++) begin
      @(negedge clk); cts_flag_clr = 1;
      @(negedge clk); cts_flag_clr = 0;
      idle(3);
      cts_n = ~cts_n;
      idle(d);
      cts_flag_clr = 1; @(negedge clk); cts_flag_clr = 0;
      idle(4);
    end
    cts_irq_en = 0; idle(3);
    cts_flag_clr = 1; @(negedge clk); cts_flag_clr = 0;

    tag = "R4";                        // disabling flow leaves cts_n high harmless
    cts_n = 1; idle(5); flow_en = 0;
    cts_flag_clr = 1; @(negedge clk); cts_flag_clr = 0;
    put(8'h81); idle(FRAME_CYC + 5);

    tag = "R10";                       // reset mid-frame
    put(8'h77); idle(9);
    @(negedge clk); rst_n = 0; idle(3);
    @(negedge clk); rst_n = 1; idle(5);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule